// File: doc/BRIEF.md
# Saturating Cascade Summer and Output Formatter

This block sits at the end of a digital upconverter's datapath. It adds the local modulator sample to a 16-bit sample that arrives from an upstream upconverter in a daisy chain. The sum is clamped to the 16-bit range, and the result is coded for a DAC bus. When no upstream device is present, a control pin forces the chain input to zero, so that the block passes only its own modulator sample.

Both addends are captured in an input register on the reference clock. The coding choice is captured in the same register. The saturated and coded sum then passes through an output register, so a result appears two clocks after its inputs. An active-low enable pin decides whether the block drives the DAC bus. The block models a disabled bus as a low drive indicator and an all-zero data word.

Top module: `casc_sum_fmt`

## Requirements
- R1: After reset, `data_o` reads 16'h0000 while `oe_ni` is 0.
- R2: While `cas_zero_i` is 1, the cascade input is treated as zero, so the result equals the modulator sample alone, whatever the value of `cas_i`.
- R3: With `oe_ni` = 0, the result of the inputs sampled on clock edge k appears on `data_o` after clock edge k+1. That is two register stages, and the coding pin is sampled on the same edge as the data.
- R4: When the signed sum lies within [-32768, 32767], the two's-complement result equals the sum exactly.
- R5: A sum above 32767 is clamped to 16'h7FFF, in two's-complement form.
- R6: A sum below -32768 is clamped to 16'h8000, in two's-complement form.
- R7: With `fmt_twos_i` = 1, the output is the two's-complement result. With `fmt_twos_i` = 0, the output is offset binary: the two's-complement result with bit 15 inverted. For example, -32768 maps to 16'h0000 and 0 maps to 16'h8000.
- R8: With `oe_ni` = 1, `drive_o` is 0 and `data_o` reads 16'h0000, in the same cycle. With `oe_ni` = 0, `drive_o` is 1. The enable pin does not disturb the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cas_i | input | 16 | Two's-complement sample from the upstream device |
| cas_zero_i | input | 1 | 1 forces the cascade input to zero |
| mod_i | input | 16 | Two's-complement local modulator sample |
| fmt_twos_i | input | 1 | 1 = two's complement output, 0 = offset binary |
| oe_ni | input | 1 | Output enable, active low |
| data_o | output | 16 | Coded sum, or zero when disabled |
| drive_o | output | 1 | 1 while the block drives the bus |

## Verification
A wrong value in the input register shows up on `data_o` exactly two clocks later. A lost zero-force therefore shows the upstream sample mixed into the result. A wrapping adder shows a sign flip where the result should be 16'h7FFF or 16'h8000. A coding error shows up as bit 15 disagreeing with the selected format. A pipeline depth error shifts every result by one cycle, and the scoreboard catches this on the first vector, because each expected item carries the cycle in which it must appear.

// File: rtl/casc_pkg.sv
package casc_pkg;
    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned SUM_W    = SAMPLE_W + 1;
endpackage

// File: rtl/casc_in_stage.sv
module casc_in_stage #(
    parameter int unsigned W = casc_pkg::SAMPLE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] cas_i,
    input  logic         cas_zero_i,
    input  logic [W-1:0] mod_i,
    input  logic         fmt_twos_i,
    output logic [W-1:0] cas_q_o,
    output logic [W-1:0] mod_q_o,
    output logic         twos_q_o
);
    typedef struct packed {
        logic [W-1:0] cas;
        logic [W-1:0] mod;
        logic         twos;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cas  = cas_zero_i ? '0 : cas_i;
        st_d.mod  = mod_i;
        st_d.twos = fmt_twos_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{cas: '0, mod: '0, twos: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cas_q_o  = st_q.cas;
    assign mod_q_o  = st_q.mod;
    assign twos_q_o = st_q.twos;

    AST_ZERO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cas_zero_i |=> (cas_q_o == '0)); // R2
endmodule

// File: rtl/casc_sat_add.sv
module casc_sat_add #(
    parameter int unsigned W = casc_pkg::SAMPLE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int unsigned EW = W + 1;
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

    logic [EW-1:0] wide;
    logic          ovf;

    always_comb begin
        wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        ovf  = wide[EW-1] ^ wide[EW-2];
        if (!ovf) begin
            sum_o = wide[W-1:0];
        end else if (wide[EW-1]) begin
            sum_o = MAX_NEG;
        end else begin
            sum_o = MAX_POS;
        end
    end

    always_comb begin
        AST_SIGN_KEPT: assert (!((a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]))); // R5
    end
endmodule

// File: rtl/casc_out_fmt.sv
module casc_out_fmt #(
    parameter int unsigned W = casc_pkg::SAMPLE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] sat_i,
    input  logic         twos_i,
    output logic [W-1:0] out_q_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (twos_i) begin
            st_d.word = sat_i;
        end else begin
            st_d.word = {~sat_i[W-1], sat_i[W-2:0]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q_o = st_q.word;

    AST_LOW_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (out_q_o[W-2:0] == $past(sat_i[W-2:0]))); // R7
endmodule

// File: rtl/casc_sum_fmt.sv
module casc_sum_fmt #(
    parameter int unsigned W = casc_pkg::SAMPLE_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] cas_i,
    input  logic         cas_zero_i,
    input  logic [W-1:0] mod_i,
    input  logic         fmt_twos_i,
    input  logic         oe_ni,
    output logic [W-1:0] data_o,
    output logic         drive_o
);
    logic [W-1:0] cas_q, mod_q, sat_w, out_q;
    logic         twos_q;

    casc_in_stage #(.W(W)) i_in (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cas_i      (cas_i),
        .cas_zero_i (cas_zero_i),
        .mod_i      (mod_i),
        .fmt_twos_i (fmt_twos_i),
        .cas_q_o    (cas_q),
        .mod_q_o    (mod_q),
        .twos_q_o   (twos_q)
    );

    casc_sat_add #(.W(W)) i_add (
        .a_i   (cas_q),
        .b_i   (mod_q),
        .sum_o (sat_w)
    );

    casc_out_fmt #(.W(W)) i_fmt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sat_i   (sat_w),
        .twos_i  (twos_q),
        .out_q_o (out_q)
    );

    always_comb begin
        drive_o = !oe_ni;
        data_o  = oe_ni ? '0 : out_q;
    end

    AST_NO_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cas_q[W-1] && !mod_q[W-1] && twos_q) |=> !out_q[W-1]); // R5
    AST_NO_NEG_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cas_q[W-1] && mod_q[W-1] && twos_q) |=> out_q[W-1]); // R6
    AST_OFFSET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cas_q == '0) && (mod_q == '0) && !twos_q) |=> (out_q == {1'b1, {(W-1){1'b0}}})); // R7
    AST_BUS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_ni |-> (!drive_o && (data_o == '0))); // R8
endmodule

// File: tb/test_casc_sum_fmt.sv
module test_casc_sum_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cas = '0;
    logic        cas_zero = 1'b0;
    logic [15:0] mod = '0;
    logic        twos = 1'b1;
    logic        oe_n = 1'b0;
    logic [15:0] data;
    logic        drive;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    casc_sum_fmt i_casc_sum_fmt (
        .clk_i(clk), .rst_ni(rst_n), .cas_i(cas), .cas_zero_i(cas_zero),
        .mod_i(mod), .fmt_twos_i(twos), .oe_ni(oe_n), .data_o(data), .drive_o(drive)
    );

    function automatic logic [15:0] model(logic [15:0] c, logic z, logic [15:0] m, logic t);
        int s;
        logic [15:0] r;
        s = (z ? 0 : int'($signed(c))) + int'($signed(m));
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r = 16'(s);
        if (!t) r = r ^ 16'h8000;
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_item(logic [15:0] c, logic z, logic [15:0] m, logic t, string req);
        item_t it;
        @(negedge clk);
        cas = c; cas_zero = z; mod = m; twos = t;
        it.due = cyc + 2;
        it.exp = model(c, z, m, t);
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: pops each expected item in the cycle it is due
    always @(posedge clk) begin
        cyc++;
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.due != cyc) begin
                checks++; errors++;
                $display("FAIL %s: item missed, actual=cycle %0d expected=cycle %0d", it.req, cyc, it.due);
            end else begin
                check(it.req, data, it.exp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset data", data, 16'h0000);
        check("R8 drive on", {15'd0, drive}, 16'h0001);

        drive_item(16'h0100, 1'b0, 16'h0023, 1'b1, "R4 small sum");
        drive_item(16'hFF00, 1'b0, 16'h0010, 1'b1, "R4 mixed signs");
        drive_item(16'h7000, 1'b0, 16'h2000, 1'b1, "R5 positive clamp");
        drive_item(16'h7FFF, 1'b0, 16'h7FFF, 1'b1, "R5 max plus max");
        drive_item(16'h8000, 1'b0, 16'hFFFF, 1'b1, "R6 negative clamp");
        drive_item(16'h9000, 1'b0, 16'hA000, 1'b1, "R6 large negatives");
        drive_item(16'h7FFF, 1'b0, 16'h0000, 1'b1, "R4 exact max");
        drive_item(16'h7FFF, 1'b1, 16'h0005, 1'b1, "R2 zero forced");
        drive_item(16'h8000, 1'b1, 16'hFFFE, 1'b1, "R2 zero forced neg");
        drive_item(16'h0000, 1'b0, 16'h0000, 1'b0, "R7 offset zero");
        drive_item(16'h8000, 1'b0, 16'h0000, 1'b0, "R7 offset min");
        drive_item(16'h7000, 1'b0, 16'h3000, 1'b0, "R7 offset clamp hi");
        drive_item(16'h1234, 1'b0, 16'h0001, 1'b1, "R3 format back to twos");
        drive_item(16'h1234, 1'b1, 16'h4321, 1'b0, "R2 R7 zero with offset");
        repeat (4) @(negedge clk);

        // Output enable: the pipeline keeps its value, the bus reads zero
        drive_item(16'h0040, 1'b0, 16'h0002, 1'b1, "R3 before disable");
        repeat (3) @(negedge clk);
        oe_n = 1'b1;
        #1;
        check("R8 data off", data, 16'h0000);
        check("R8 drive off", {15'd0, drive}, 16'h0000);
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        check("R8 value held", data, 16'h0042);
        check("R8 drive back", {15'd0, drive}, 16'h0001);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R3: pending items actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule